// File: doc/BRIEF.md
# Converter Reset Sequencer

This block resets a group of high-speed data converters so that their output data clocks line up. A start request produces one active-high reset pulse. The pulse goes to every converter on the same logic clock edge. The block then waits out the interval in which the converters' output timing settles, and after that the interval the converters need to calibrate themselves. When both intervals are over it raises a ready flag. Downstream capture logic uses that flag to decide when converter data is valid.

The logic runs at one quarter of the converters' sample rate. The converters count the minimum pulse width in sample-clock periods, so the pulse is held for a whole number of logic cycles. That number is never fewer than two, which keeps the pulse well above four sample periods. The settle and calibration intervals are also parameters counted in logic cycles.

Each converter also has an out-of-range flag. The block stretches every flag on its own so that a one-cycle event still stays visible long enough to drive an indicator lamp.

Top module: `cnv_rst_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every bit of `cnv_rst_o`, `ready_o` and every bit of `oor_led_o` reads 0.
- R2: A start request (`start_i` high at a clock edge) taken in the idle or ready state drives every bit of `cnv_rst_o` high from that edge on, all on the same edge, for exactly PULSE_CYC cycles (PULSE_CYC is taken as 2 if it is set lower).
- R3: `ready_o` rises exactly RECOV_CYC + CAL_CYC cycles after `cnv_rst_o` falls, and stays 0 until then.
- R4: `ready_o` is never high while any bit of `cnv_rst_o` is high. Once it is high, it stays high until the next start request is taken.
- R5: A start request that arrives while the pulse, settle or calibration interval is running is ignored: the pulse width and the time at which `ready_o` rises do not change.
- R6: A start request in the ready state restarts the sequence: `ready_o` falls on the same edge at which `cnv_rst_o` rises.
- R7: When bit k of `oor_i` is high at an edge, bit k of `oor_led_o` is high from that edge for exactly OOR_HOLD cycles, and no other bit of `oor_led_o` is affected.
- R8: A further high sample of an out-of-range flag while its indicator is already lit restarts the OOR_HOLD window from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock, one quarter of the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the reset sequence |
| oor_i | input | NUM_CNV | Out-of-range flags, one per converter |
| cnv_rst_o | output | NUM_CNV | Reset pulse, one identical bit per converter |
| ready_o | output | 1 | Converter data valid for capture |
| oor_led_o | output | NUM_CNV | Stretched out-of-range indicators |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of the sequence. It has to be shown to have no effect, and this must hold on every cycle of the pulse, settle and calibration windows, including the last calibration cycle just before the ready state. The bench runs the sequence once for each possible offset of that stray request. It predicts the pulse and ready waveform arithmetically from the cycle count since the accepted start. The out-of-range stretchers are swept with every six-bit pattern of flag activity, given to the two converters in complementary form, so that retriggers, back-to-back events and isolated one-cycle events are all compared with a counter model.

// File: rtl/cnv_rst_pkg.sv
package cnv_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_RECOVER,
        ST_CAL_WAIT,
        ST_READY
    } seq_state_t;

    typedef struct packed {
        logic       load;
        seq_state_t nxt;
    } seq_ctl_t;

    function automatic int unsigned at_least(int unsigned v, int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/seq_interval_cnt.sv
module seq_interval_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import cnv_rst_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 2,
    parameter int unsigned RECOV_LEN = 2,
    parameter int unsigned CAL_LEN   = 8,
    parameter int unsigned CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          expired_i,
    output logic [CW-1:0] load_val_o,
    output seq_ctl_t      ctl_o
);
    localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_LEN - 1);
    localparam logic [CW-1:0] LD_RECOV = CW'(RECOV_LEN - 1);
    localparam logic [CW-1:0] LD_CAL   = CW'(CAL_LEN - 1);

    seq_state_t state_q;

    always_comb begin
        ctl_o.nxt  = state_q;
        ctl_o.load = 1'b0;
        load_val_o = '0;
        case (state_q)
            ST_IDLE, ST_READY: begin
                if (start_i) begin
                    ctl_o.nxt  = ST_PULSE;
                    ctl_o.load = 1'b1;
                    load_val_o = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (expired_i) begin
                    ctl_o.nxt  = ST_RECOVER;
                    ctl_o.load = 1'b1;
                    load_val_o = LD_RECOV;
                end
            end
            ST_RECOVER: begin
                if (expired_i) begin
                    ctl_o.nxt  = ST_CAL_WAIT;
                    ctl_o.load = 1'b1;
                    load_val_o = LD_CAL;
                end
            end
            ST_CAL_WAIT: begin
                if (expired_i) begin
                    ctl_o.nxt = ST_READY;
                end
            end
            default: ctl_o.nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= ctl_o.nxt;
        end
    end
endmodule

// File: rtl/oor_stretch.sv
module oor_stretch
    import cnv_rst_pkg::*;
#(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic led_o
);
    localparam int unsigned HOLD_EFF = at_least(HOLD, 1);
    localparam int unsigned HW       = cnt_width(HOLD_EFF);
    localparam logic [HW-1:0] LD_HOLD = HW'(HOLD_EFF - 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            led_o  <= 1'b0;
        end else if (flag_i) begin
            left_q <= LD_HOLD;
            led_o  <= 1'b1;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else begin
            led_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/cnv_rst_seq.sv
module cnv_rst_seq
    import cnv_rst_pkg::*;
#(
    parameter int unsigned NUM_CNV   = 2,
    parameter int unsigned PULSE_CYC = 2,
    parameter int unsigned RECOV_CYC = 2,
    parameter int unsigned CAL_CYC   = 4096,
    parameter int unsigned OOR_HOLD  = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [NUM_CNV-1:0] oor_i,
    output logic [NUM_CNV-1:0] cnv_rst_o,
    output logic               ready_o,
    output logic [NUM_CNV-1:0] oor_led_o
);
    localparam int unsigned P_EFF = at_least(PULSE_CYC, 2);
    localparam int unsigned R_EFF = at_least(RECOV_CYC, 1);
    localparam int unsigned C_EFF = at_least(CAL_CYC, 1);
    localparam int unsigned CW    = cnt_width(max3(P_EFF, R_EFF, C_EFF));

    seq_ctl_t      ctl;
    logic [CW-1:0] load_val;
    logic          expired;

    seq_fsm #(
        .PULSE_LEN (P_EFF),
        .RECOV_LEN (R_EFF),
        .CAL_LEN   (C_EFF),
        .CW        (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .expired_i  (expired),
        .load_val_o (load_val),
        .ctl_o      (ctl)
    );

    seq_interval_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl.load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    // one output flop per converter, all fed from the same next-state decode
    for (genvar k = 0; k < NUM_CNV; k++) begin : g_cnv
        always_ff @(posedge clk) begin
            if (rst) begin
                cnv_rst_o[k] <= 1'b0;
            end else begin
                cnv_rst_o[k] <= (ctl.nxt == ST_PULSE);
            end
        end

        oor_stretch #(.HOLD(OOR_HOLD)) u_oor (
            .clk    (clk),
            .rst    (rst),
            .flag_i (oor_i[k]),
            .led_o  (oor_led_o[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_o <= 1'b0;
        end else begin
            ready_o <= (ctl.nxt == ST_READY);
        end
    end
endmodule

// File: rtl/cnv_rst_seq_chk.sv
module cnv_rst_seq_chk #(
    parameter int unsigned NUM_CNV = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [NUM_CNV-1:0] oor_i,
    input logic [NUM_CNV-1:0] cnv_rst_o,
    input logic               ready_o,
    input logic [NUM_CNV-1:0] oor_led_o
);
    // R2: all converters see the same pulse level on every cycle
    a_r2_common_pulse: assert property (@(posedge clk) disable iff (rst)
        ($countones(cnv_rst_o) == 0) || ($countones(cnv_rst_o) == NUM_CNV));

    // R2: a pulse lasts at least two logic cycles
    a_r2_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_rst_o[0]) |=> cnv_rst_o[0]);

    // R4: ready and reset pulse never overlap
    a_r4_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(ready_o && (|cnv_rst_o)));

    // R4: ready holds without a start request
    a_r4_ready_hold: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> ready_o);

    // R3: ready only rises after the pulse has been low for a cycle
    a_r3_ready_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> !$past(cnv_rst_o[0]));

    // R6: a start in ready drops ready and raises the pulse together
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> (!ready_o && cnv_rst_o[0]));

    for (genvar k = 0; k < NUM_CNV; k++) begin : g_led
        // R7: an out-of-range sample lights its indicator on the next cycle
        a_r7_led_set: assert property (@(posedge clk) disable iff (rst)
            oor_i[k] |=> oor_led_o[k]);
    end
endmodule

bind cnv_rst_seq cnv_rst_seq_chk #(.NUM_CNV(NUM_CNV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .oor_i     (oor_i),
    .cnv_rst_o (cnv_rst_o),
    .ready_o   (ready_o),
    .oor_led_o (oor_led_o)
);

// File: tb/sim_cnv_rst_seq.sv
`timescale 1ns/1ps
module sim_cnv_rst_seq;
    localparam int P = 3;
    localparam int R = 2;
    localparam int C = 5;
    localparam int H = 4;
    localparam int N = 2;
    localparam int T = P + R + C;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [N-1:0] oor_i;
    logic [N-1:0] cnv_rst_o;
    logic         ready_o;
    logic [N-1:0] oor_led_o;

    int vec = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cnv_rst_seq #(
        .NUM_CNV(N), .PULSE_CYC(P), .RECOV_CYC(R), .CAL_CYC(C), .OOR_HOLD(H)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .oor_i(oor_i),
        .cnv_rst_o(cnv_rst_o), .ready_o(ready_o), .oor_led_o(oor_led_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(logic got, logic exp, string req, string what);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%b exp=%b t=%0t", req, what, got, exp, $time);
        end
    endtask

    // begins at a negedge in idle or ready; stray start at offset extra (<0: none)
    task automatic run_seq(int extra, string req);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 0; k <= T + 1; k++) begin
            for (int b = 0; b < N; b++) chk(cnv_rst_o[b], k < P, req, "pulse");
            chk(ready_o, k >= T, req, "ready");
            start_i = (k == extra) && (k < T);
            step();
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int since [N];
        logic [N-1:0] v;
        rst = 1'b1;
        start_i = 1'b0;
        oor_i = '0;
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk(|cnv_rst_o, 1'b0, "R1", "pulse in reset");
        chk(ready_o, 1'b0, "R1", "ready in reset");
        chk(|oor_led_o, 1'b0, "R1", "led in reset");
        rst = 1'b0;
        step();
        chk(|cnv_rst_o, 1'b0, "R1", "pulse after reset");
        chk(ready_o, 1'b0, "R1", "ready after reset");
        for (int i = 0; i < 4; i++) begin
            step();
            chk(ready_o, 1'b0, "R4", "idle ready");
        end

        run_seq(-1, "R2");
        for (int i = 0; i < 6; i++) begin
            step();
            chk(ready_o, 1'b1, "R4", "ready holds");
        end
        run_seq(-1, "R6");
        for (int j = 0; j < T; j++) run_seq(j, "R5");
        run_seq(-1, "R3");

        // R7 / R8: stretch sweep, complementary patterns per converter
        for (int b = 0; b < N; b++) since[b] = 1000;
        for (int p = 0; p < 64; p++) begin
            for (int i = 0; i < 6 + H + 2; i++) begin
                v[0] = (i < 6) ? p[i] : 1'b0;
                v[1] = (i < 6) ? ~p[i] : 1'b0;
                oor_i = v;
                step();
                for (int b = 0; b < N; b++) begin
                    string tag;
                    tag = (v[b] && since[b] < H) ? "R8" : "R7";
                    since[b] = v[b] ? 0 : since[b] + 1;
                    chk(oor_led_o[b], since[b] < H, tag, "led");
                end
            end
        end
        oor_i = '0;

        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule